// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Sine PWM Gate Generator

This block drives the gates of one phase leg of a five-level neutral-clamped inverter. It uses sine-triangle modulation in which four triangular carriers with the same frequency and the same height sit one above another. Together they cover one unbroken amplitude range. A signed reference sample comes from an external sine source on a valid/ready stream. The block re-centres that sample on the middle of the carrier stack and compares it with every carrier. Each comparison commands one upper switch and its lower complement. A programmable dead time is placed between the two switches of each pair.

All four carriers come from a single up/down counter. The counter climbs from zero to a programmed peak P and falls back, and carrier k is that count plus k·P. The total span is therefore 4·P. The reference is shifted up by 2·P before it is compared. The modulation index is the peak-to-peak reference divided by four carrier heights. The frequency ratio is the carrier rate over the reference rate, and the carrier period is 2·P clock cycles.

The reference stream never applies back-pressure: `ref_ready` is always high. A cycle with `ref_valid` low freezes all four commands at their last values. `cfg_peak` and `cfg_dead` are plain configuration pins.

Top module: `lscp_leg`

## Requirements
- R1: While reset is asserted, every upper and lower gate output is 0, and the counter restarts from 0 counting up.
- R2: Carrier k (k = 0..3) equals count + k·P, so the four carriers tile the range 0..4·P with no gap and no overlap.
- R3: The reference is compared after adding 2·P. A reference above +2·P turns every upper switch on, below −2·P turns every lower switch on, and 0 turns pairs 0 and 1 upper and pairs 2 and 3 lower.
- R4: For pair k, a shifted reference above carrier k commands the upper switch on and below it commands it off. Equality keeps the previous command. With P=8 and reference −4, pair 1 is commanded upper for 8 of every 16 cycles.
- R5: Whenever a pair's command changes, both of its gates are 0 for exactly cfg_dead+1 cycles before the new side turns on. The upper and lower gate of a pair are never 1 together.
- R6: A new cfg_peak is adopted only in a cycle where the counter is 0. The running peak never changes while the count is non-zero.
- R7: `ref_ready` is always 1. While `ref_valid` is 0, all commands hold and the gates do not change state.
- R8: The counter moves by exactly one each cycle, 0 up to P and back to 0, giving a carrier period of 2·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_peak | input | CW | Carrier band height P (counter peak), at least 1 |
| cfg_dead | input | DW | Dead-time length in cycles, minus one |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Always 1; the block accepts a sample every cycle |
| ref_sample | input | CAW+1 | Signed reference, CAW = CW + log2(NCAR) |
| gate_hi | output | NCAR | Upper switch commands, bit k for pair k |
| gate_lo | output | NCAR | Lower (complementary) switch commands |

## Verification
The assertions assume that `cfg_peak` is never 0 and that `cfg_dead` changes only while no pair is in a dead interval. They also assume that the reference stays within ±(2·P + 1), so that the shifted value fits its width. The directed stimulus uses band heights of 4 and 8 and dead times of 1 and 2. Each setting is applied and then given several full carrier periods to settle before any window is counted. References are chosen on band edges, on band midpoints and just outside the stack, so that equality holding and saturation are both exercised within those limits.

// File: rtl/lscp_pkg.sv
package lscp_pkg;
  // Width of a carrier value for NCAR bands of a CW-bit counter.
  function automatic int car_width(input int cw, input int ncar);
    return cw + $clog2(ncar);
  endfunction
endpackage

// File: rtl/lscp_tri_counter.sv
module lscp_tri_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_peak,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] band,
  output logic [CW-1:0] peak_q
);
  logic [CW-1:0] cnt_q;
  logic          up_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);
  // Configuration is taken up only at the bottom of the triangle.
  assign band    = at_zero ? cfg_peak : peak_q;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      peak_q <= '0;
    end else begin
      if (at_zero) peak_q <= cfg_peak;
      if (up_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (({1'b0, cnt_q} + 1'b1) >= {1'b0, band}) up_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) up_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lscp_band_cmp.sv
module lscp_band_cmp #(
  parameter int CW   = 10,
  parameter int NCAR = 4,
  parameter int CAW  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         cnt,
  input  logic [CW-1:0]         band,
  input  logic                  ref_valid,
  input  logic signed [CAW:0]   ref_sample,
  output logic [NCAR-1:0]       cmd
);
  logic [CAW-1:0]          half_span;
  logic signed [CAW+1:0]   uref;

  assign half_span = CAW'(NCAR / 2) * CAW'(band);
  assign uref = $signed({ref_sample[CAW], ref_sample}) + $signed({2'b00, half_span});

  for (genvar k = 0; k < NCAR; k++) begin : g_band
    logic [CAW-1:0]        car;
    logic signed [CAW+1:0] car_s;
    logic                  on_q;

    assign car   = CAW'(cnt) + CAW'(k) * CAW'(band);
    assign car_s = $signed({2'b00, car});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q <= 1'b0;
      end else if (ref_valid) begin
        if (uref > car_s)      on_q <= 1'b1;
        else if (uref < car_s) on_q <= 1'b0;
      end
    end

    assign cmd[k] = on_q;
  end
endmodule

// File: rtl/lscp_deadtime.sv
module lscp_deadtime #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd,
  input  logic [DW-1:0] cfg_dead,
  output logic          hi,
  output logic          lo
);
  logic          cur_q;
  logic [DW-1:0] tmr_q;
  logic          hi_q;
  logic          lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      tmr_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (cmd != cur_q) begin
      cur_q <= cmd;
      tmr_q <= cfg_dead;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end else begin
      hi_q <= cur_q;
      lo_q <= ~cur_q;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/lscp_leg.sv
module lscp_leg
  import lscp_pkg::*;
#(
  parameter int  CW   = 10,
  parameter int  DW   = 8,
  parameter int  NCAR = 4,
  localparam int CAW  = car_width(CW, NCAR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        cfg_peak,
  input  logic [DW-1:0]        cfg_dead,
  input  logic                 ref_valid,
  output logic                 ref_ready,
  input  logic signed [CAW:0]  ref_sample,
  output logic [NCAR-1:0]      gate_hi,
  output logic [NCAR-1:0]      gate_lo
);
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   band;
  logic [CW-1:0]   peak_q;
  logic [NCAR-1:0] cmd;

  assign ref_ready = 1'b1;

  lscp_tri_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_peak (cfg_peak),
    .cnt      (cnt),
    .band     (band),
    .peak_q   (peak_q)
  );

  lscp_band_cmp #(.CW(CW), .NCAR(NCAR), .CAW(CAW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .band       (band),
    .ref_valid  (ref_valid),
    .ref_sample (ref_sample),
    .cmd        (cmd)
  );

  for (genvar k = 0; k < NCAR; k++) begin : g_pair
    lscp_deadtime #(.DW(DW)) u_dt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd[k]),
      .cfg_dead (cfg_dead),
      .hi       (gate_hi[k]),
      .lo       (gate_lo[k])
    );
  end
endmodule

// File: rtl/lscp_leg_chk.sv
module lscp_leg_chk #(
  parameter int CW   = 10,
  parameter int NCAR = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   peak_q,
  input logic [NCAR-1:0] cmd,
  input logic            ref_valid,
  input logic [NCAR-1:0] gate_hi,
  input logic [NCAR-1:0] gate_lo
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R5

  AST_PEAK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(peak_q)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt <= peak_q)); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R8

  AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> $stable(cmd)); // R7

  for (genvar k = 0; k < NCAR; k++) begin : g_gap
    AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[k]) |-> !$past(gate_lo[k])); // R5
    AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[k]) |-> !$past(gate_hi[k])); // R5
  end
endmodule

bind lscp_leg lscp_leg_chk #(.CW(CW), .NCAR(NCAR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt),
  .peak_q    (peak_q),
  .cmd       (cmd),
  .ref_valid (ref_valid),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo)
);

// File: tb/test_lscp_leg.sv
`timescale 1ns/1ps
module test_lscp_leg;
  localparam int CW   = 10;
  localparam int DW   = 8;
  localparam int NCAR = 4;
  localparam int CAW  = CW + $clog2(NCAR);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [CW-1:0]       cfg_peak = CW'(8);
  logic [DW-1:0]       cfg_dead = DW'(2);
  logic                ref_valid = 1'b1;
  logic                ref_ready;
  logic signed [CAW:0] ref_sample = '0;
  logic [NCAR-1:0]     gate_hi;
  logic [NCAR-1:0]     gate_lo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lscp_leg #(.CW(CW), .DW(DW), .NCAR(NCAR)) i_lscp_leg (
    .clk(clk), .rst_n(rst_n), .cfg_peak(cfg_peak), .cfg_dead(cfg_dead),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_sample(ref_sample),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  // R1: outputs idle while reset is held
  task automatic t_reset();
    rst_n = 1'b0;
    settle(4);
    check("R1 gate_hi in reset", int'(gate_hi), 0);
    check("R1 gate_lo in reset", int'(gate_lo), 0);
    rst_n = 1'b1;
  endtask

  // R3: saturation above and below the stack
  task automatic t_saturate();
    cfg_peak = CW'(8); cfg_dead = DW'(2); ref_valid = 1'b1;
    ref_sample = (CAW+1)'(17);
    settle(80);
    check("R3 high ref gate_hi", int'(gate_hi), 15);
    check("R3 high ref gate_lo", int'(gate_lo), 0);
    ref_sample = -(CAW+1)'(17);
    settle(80);
    check("R3 low ref gate_hi", int'(gate_hi), 0);
    check("R3 low ref gate_lo", int'(gate_lo), 15);
  endtask

  // R2 R3 R4: zero reference sits on the boundary between bands 1 and 2
  task automatic t_centre();
    int bad = 0;
    ref_sample = '0;
    settle(80);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (gate_hi != 4'b0011 || gate_lo != 4'b1100) bad++;
    end
    check("R2 centre reference stable split", bad, 0);
    check("R3 centre gate_hi", int'(gate_hi), 3);
  endtask

  // R4 R5 R8: duty and dead-time in pair 1 over whole periods
  task automatic t_duty(input int b, input int d, input int r,
                        input int exp_hi, input int exp_lo, input string tag);
    int on_hi = 0, on_lo = 0, edges = 0, both = 0;
    logic prev;
    cfg_peak = CW'(b); cfg_dead = DW'(d); ref_sample = (CAW+1)'(r);
    settle(8 * 2 * b + d + 10);
    prev = gate_hi[1];
    for (int i = 0; i < 4 * 2 * b; i++) begin
      @(negedge clk);
      if (gate_hi[1]) on_hi++;
      if (gate_lo[1]) on_lo++;
      if (gate_hi[1] && !prev) edges++;
      prev = gate_hi[1];
      if ((gate_hi & gate_lo) != '0) both++;
    end
    check({"R4 upper on-time ", tag}, on_hi, 4 * exp_hi);
    check({"R5 lower on-time ", tag}, on_lo, 4 * exp_lo);
    check({"R8 pulses per window ", tag}, edges, 4);
    check({"R5 no overlap ", tag}, both, 0);
  endtask

  // R7: invalid samples are ignored, ready stays high
  task automatic t_valid();
    cfg_peak = CW'(8); cfg_dead = DW'(2);
    ref_valid = 1'b1; ref_sample = (CAW+1)'(17);
    settle(80);
    ref_valid = 1'b0; ref_sample = -(CAW+1)'(17);
    settle(60);
    check("R7 gate_hi held while invalid", int'(gate_hi), 15);
    check("R7 gate_lo held while invalid", int'(gate_lo), 0);
    check("R7 ready high", int'(ref_ready), 1);
    ref_valid = 1'b1;
    settle(20);
    check("R7 sample taken once valid", int'(gate_lo), 15);
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_centre();
    // P=8, ref -4 -> shifted 12, command 8 of 16; dead 2 removes 3 per side
    t_duty(8, 2, -4, 5, 5, "P8 D2");
    // R6: period change to P=4, ref -2 -> shifted 6, command 4 of 8; dead 1 removes 2
    t_duty(4, 1, -2, 2, 2, "R6 P4 D1");
    t_valid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule